// File: doc/BRIEF.md
# Subpage ECC Buffer Sequencer

This block moves one flash page through an internal buffer window. It handles the page as a series of 512-byte subpages, and the host starts each subpage with its own trigger. The host reaches the buffer with word accesses on a small select/strobe interface. An ECC engine sits behind a start/done/result port and reaches the same buffer through a port of its own while it runs. The block keeps count of the words in each frame, checks that every host access arrives in a phase that allows it, drives a controller-ready indication, and latches the decoder result for each subpage.

To write a subpage, the host sends an encode-start trigger, pushes 128 data words, then one full spare word and one half-word spare write, and then sends an auto-encode trigger. Ready stays low until the engine reports done. To read a subpage, the host sends an auto-decode trigger and waits for ready. It then pops 128 data words and 4 spare words in order. Spare words 2 and 3 (spare bytes 8 to 15) are where the engine keeps its parity.

Top module: `subpage_ecc_seq`

## Requirements
- R1: After reset, ctrl_ready is 1, seq_err is 0, sub_idx is 0, ecc_start is 0, and dec_fail, dec_errs and dec_corr are all 0.
- R2: The host select codes are 0 = buffer window, 1 = encode-start, 2 = auto-encode and 3 = auto-decode. The write frame runs as follows. An encode-start write in the idle phase opens the frame. Buffer writes 0 to 128 must be full words (host_half=0). Buffer write 129 must be a half write (host_half=1). After that write, an auto-encode write produces a one-cycle ecc_start with ecc_mode=0 in the cycle after the trigger. ctrl_ready is 0 from that cycle until the cycle after ecc_done.
- R3: While the engine runs, eng_rdata shows, without delay, the buffer word at eng_addr. Data word k sits at index k, the full spare word sits at 128, and the half write sits at 129. The half write changes only the lower 16 bits of that word (with the default lane setting) and leaves the upper 16 bits unchanged.
- R4: An auto-decode write in the idle phase produces a one-cycle ecc_start with ecc_mode=1 and drops ctrl_ready. eng_we writes full words to the buffer only while ctrl_ready is 0, and has no effect at any other time. After ecc_done, 132 buffer reads return indices 0 to 131 in order, each on host_rdata during the cycle in which host_rd is high. After the 132nd read the block returns to idle.
- R5: On ecc_done during a decode, the block latches the result. ecc_fail gives dec_fail=1 and dec_corr=0. Otherwise ecc_errs gives dec_errs=1 and dec_corr=ecc_cnt+1. With neither flag set, all three outputs are 0. The result holds through encodes and changes only at the next decode done.
- R6: sub_idx advances by one at each encode done and at the last read of each decode frame. It wraps to 0 after PAGE_BYTES/512 subpages.
- R7: Any host access not allowed in the current phase sets seq_err, which then stays set until reset. This includes a buffer access outside its frame, a write of the wrong size, a trigger in the wrong phase, and any access while busy. Such an access changes neither the word count, the phase nor the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 2 | 0 buffer, 1 encode-start, 2 auto-encode, 3 auto-decode |
| host_half | input | 1 | Half-word buffer write |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Buffer word at the read pointer during a read frame, else 0 |
| ctrl_ready | output | 1 | Low while the engine runs |
| seq_err | output | 1 | Sticky sequencing error |
| sub_idx | output | SUB_W | Subpage index within the page |
| dec_fail | output | 1 | Last decode was uncorrectable |
| dec_errs | output | 1 | Last decode corrected errors |
| dec_corr | output | 3 | Symbols corrected by the last decode |
| ecc_start | output | 1 | One-cycle engine start |
| ecc_mode | output | 1 | 0 encode, 1 decode |
| ecc_done | input | 1 | Engine finished |
| ecc_fail | input | 1 | Decode result: uncorrectable |
| ecc_errs | input | 1 | Decode result: errors corrected |
| ecc_cnt | input | 2 | Corrected count minus one |
| eng_addr | input | AW | Engine buffer index |
| eng_we | input | 1 | Engine buffer write |
| eng_wdata | input | DW | Engine write data |
| eng_rdata | output | DW | Buffer word at eng_addr |

## Verification
Some properties are checked on every cycle:
- ecc_start is a single-cycle pulse issued while busy.
- Ready returns high in the cycle after done.
- Any host strobe while busy leaves seq_err set.
- seq_err never clears.
- sub_idx moves only by one step with wrap.
- The decode result changes only after a done from the busy state, and a failure never carries a corrected count.

Other behaviour depends on data and order, so only the bench scenarios can show it:
- The buffer contents seen by the engine and then by the host.
- Lane merging for the half write.
- Rejection of early triggers and wrong-size writes without any change to the count.
- Engine writes being ignored while idle.
- The index wrapping across a full 4096-byte page.

// File: rtl/sp_pkg.sv
package sp_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_FILL,
      PH_ARMED,
      PH_ENC,
      PH_DEC,
      PH_DRAIN
   } phase_t;

   localparam logic [1:0] SEL_BUF      = 2'd0;
   localparam logic [1:0] SEL_ENC_OPEN = 2'd1;
   localparam logic [1:0] SEL_AUTO_ENC = 2'd2;
   localparam logic [1:0] SEL_AUTO_DEC = 2'd3;
endpackage

// File: rtl/sp_buffer.sv
module sp_buffer #(
   parameter int unsigned WORDS = 132,
   parameter int unsigned AW    = 8,
   parameter int unsigned DW    = 32,
   localparam int unsigned NB   = DW / 8
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [NB-1:0] wr_be,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr_a,
   output logic [DW-1:0] rd_data_a,
   input  logic [AW-1:0] rd_addr_b,
   output logic [DW-1:0] rd_data_b
);
   logic [DW-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int b = 0; b < NB; b++) begin
            if (wr_be[b]) mem[wr_addr][b*8 +: 8] <= wr_data[b*8 +: 8];
         end
      end
   end

   assign rd_data_a = mem[rd_addr_a];
   assign rd_data_b = mem[rd_addr_b];
endmodule

// File: rtl/sp_phase_ctrl.sv
module sp_phase_ctrl import sp_pkg::*; #(
   parameter int unsigned DATA_WORDS = 128,
   parameter int unsigned BUF_WORDS  = 132,
   parameter int unsigned AW         = 8,
   parameter int unsigned SUBPAGES   = 4,
   parameter int unsigned SUB_W      = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_wr,
   input  logic             host_rd,
   input  logic [1:0]       host_sel,
   input  logic             host_half,
   input  logic             ecc_done,
   output phase_t           phase,
   output logic [AW-1:0]    cnt,
   output logic             buf_wr_ok,
   output logic             ecc_start,
   output logic             seq_err,
   output logic [SUB_W-1:0] sub_idx,
   output logic             dec_done
);
   localparam logic [AW-1:0] HALF_IDX = AW'(DATA_WORDS + 1);
   localparam logic [AW-1:0] LAST_RD  = AW'(BUF_WORDS - 1);

   logic acc_rd, acc_open, acc_aenc, acc_adec, acc_wr, bad, sub_step;

   assign buf_wr_ok = host_wr && host_sel == SEL_BUF && phase == PH_FILL &&
                      (host_half == (cnt == HALF_IDX));
   assign acc_rd    = host_rd && host_sel == SEL_BUF && phase == PH_DRAIN;
   assign acc_open  = host_wr && host_sel == SEL_ENC_OPEN && phase == PH_IDLE;
   assign acc_aenc  = host_wr && host_sel == SEL_AUTO_ENC && phase == PH_ARMED;
   assign acc_adec  = host_wr && host_sel == SEL_AUTO_DEC && phase == PH_IDLE;
   assign acc_wr    = buf_wr_ok || acc_open || acc_aenc || acc_adec;
   assign bad       = (host_wr && !acc_wr) || (host_rd && !acc_rd);
   assign dec_done  = phase == PH_DEC && ecc_done;
   assign sub_step  = (phase == PH_ENC && ecc_done) || (acc_rd && cnt == LAST_RD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         cnt       <= '0;
         ecc_start <= 1'b0;
         seq_err   <= 1'b0;
         sub_idx   <= '0;
      end else begin
         ecc_start <= acc_aenc || acc_adec;
         if (bad) seq_err <= 1'b1;
         if (sub_step) sub_idx <= (sub_idx == SUB_W'(SUBPAGES - 1)) ? '0 : sub_idx + 1'b1;
         unique case (phase)
            PH_IDLE: begin
               if (acc_open) begin
                  phase <= PH_FILL;
                  cnt   <= '0;
               end else if (acc_adec) begin
                  phase <= PH_DEC;
               end
            end
            PH_FILL: begin
               if (buf_wr_ok) begin
                  if (cnt == HALF_IDX) begin
                     phase <= PH_ARMED;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            PH_ARMED: if (acc_aenc) phase <= PH_ENC;
            PH_ENC:   if (ecc_done) phase <= PH_IDLE;
            PH_DEC: begin
               if (ecc_done) begin
                  phase <= PH_DRAIN;
                  cnt   <= '0;
               end
            end
            PH_DRAIN: begin
               if (acc_rd) begin
                  if (cnt == LAST_RD) begin
                     phase <= PH_IDLE;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sp_status.sv
module sp_status (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       capture,
   input  logic       fail_in,
   input  logic       errs_in,
   input  logic [1:0] cnt_in,
   output logic       dec_fail,
   output logic       dec_errs,
   output logic [2:0] dec_corr
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_fail <= 1'b0;
         dec_errs <= 1'b0;
         dec_corr <= '0;
      end else if (capture) begin
         dec_fail <= fail_in;
         dec_errs <= !fail_in && errs_in;
         dec_corr <= (!fail_in && errs_in) ? {1'b0, cnt_in} + 3'd1 : 3'd0;
      end
   end
endmodule

// File: rtl/subpage_ecc_seq.sv
module subpage_ecc_seq import sp_pkg::*; #(
   parameter int unsigned SUB_BYTES  = 512,
   parameter int unsigned PAGE_BYTES = 2048,
   parameter int unsigned DW         = 32,
   parameter bit          HALF_UPPER = 1'b0,
   localparam int unsigned NB         = DW / 8,
   localparam int unsigned DATA_WORDS = SUB_BYTES / NB,
   localparam int unsigned BUF_WORDS  = DATA_WORDS + 16 / NB,
   localparam int unsigned AW         = $clog2(BUF_WORDS),
   localparam int unsigned SUBPAGES   = PAGE_BYTES / SUB_BYTES,
   localparam int unsigned SUB_W      = (SUBPAGES > 1) ? $clog2(SUBPAGES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_wr,
   input  logic             host_rd,
   input  logic [1:0]       host_sel,
   input  logic             host_half,
   input  logic [DW-1:0]    host_wdata,
   output logic [DW-1:0]    host_rdata,
   output logic             ctrl_ready,
   output logic             seq_err,
   output logic [SUB_W-1:0] sub_idx,
   output logic             dec_fail,
   output logic             dec_errs,
   output logic [2:0]       dec_corr,
   output logic             ecc_start,
   output logic             ecc_mode,
   input  logic             ecc_done,
   input  logic             ecc_fail,
   input  logic             ecc_errs,
   input  logic [1:0]       ecc_cnt,
   input  logic [AW-1:0]    eng_addr,
   input  logic             eng_we,
   input  logic [DW-1:0]    eng_wdata,
   output logic [DW-1:0]    eng_rdata
);
   if (DW != 32) begin : g_bad_dw
      $error("spare layout needs 32-bit words");
   end
   if (PAGE_BYTES % SUB_BYTES != 0 || SUBPAGES < 1) begin : g_bad_page
      $error("page must be a whole number of subpages");
   end

   phase_t        phase;
   logic [AW-1:0] cnt;
   logic          buf_wr_ok, dec_done, busy;
   logic [NB-1:0] half_be;
   logic [DW-1:0] half_data;
   logic          w_en;
   logic [AW-1:0] w_addr;
   logic [NB-1:0] w_be;
   logic [DW-1:0] w_data, rd_a;

   if (HALF_UPPER) begin : g_half_hi
      assign half_be   = {{(NB/2){1'b1}}, {(NB/2){1'b0}}};
      assign half_data = {host_wdata[DW/2-1:0], {(DW/2){1'b0}}};
   end else begin : g_half_lo
      assign half_be   = {{(NB/2){1'b0}}, {(NB/2){1'b1}}};
      assign half_data = host_wdata;
   end

   sp_phase_ctrl #(
      .DATA_WORDS(DATA_WORDS), .BUF_WORDS(BUF_WORDS), .AW(AW),
      .SUBPAGES(SUBPAGES), .SUB_W(SUB_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_sel(host_sel), .host_half(host_half), .ecc_done(ecc_done),
      .phase(phase), .cnt(cnt), .buf_wr_ok(buf_wr_ok), .ecc_start(ecc_start),
      .seq_err(seq_err), .sub_idx(sub_idx), .dec_done(dec_done)
   );

   assign busy       = phase == PH_ENC || phase == PH_DEC;
   assign ctrl_ready = !busy;
   assign ecc_mode   = phase == PH_DEC;

   always_comb begin
      if (busy && eng_we) begin
         w_en   = 1'b1;
         w_addr = eng_addr;
         w_be   = '1;
         w_data = eng_wdata;
      end else begin
         w_en   = buf_wr_ok;
         w_addr = cnt;
         w_be   = host_half ? half_be : '1;
         w_data = host_half ? half_data : host_wdata;
      end
   end

   sp_buffer #(.WORDS(BUF_WORDS), .AW(AW), .DW(DW)) u_buf (
      .clk(clk), .wr_en(w_en), .wr_addr(w_addr), .wr_be(w_be), .wr_data(w_data),
      .rd_addr_a(cnt), .rd_data_a(rd_a), .rd_addr_b(eng_addr), .rd_data_b(eng_rdata)
   );

   assign host_rdata = (phase == PH_DRAIN) ? rd_a : '0;

   sp_status u_stat (
      .clk(clk), .rst_n(rst_n), .capture(dec_done), .fail_in(ecc_fail),
      .errs_in(ecc_errs), .cnt_in(ecc_cnt), .dec_fail(dec_fail),
      .dec_errs(dec_errs), .dec_corr(dec_corr)
   );
endmodule

// File: rtl/sp_seq_checker.sv
module sp_seq_checker #(
   parameter int unsigned SUBPAGES = 4,
   parameter int unsigned SUB_W    = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_wr,
   input logic             host_rd,
   input logic             ctrl_ready,
   input logic             ecc_start,
   input logic             ecc_done,
   input logic             seq_err,
   input logic [SUB_W-1:0] sub_idx,
   input logic             dec_fail,
   input logic             dec_errs,
   input logic [2:0]       dec_corr
);
   assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ecc_start |-> !ctrl_ready);
   assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ecc_start |=> !ecc_start);
   assert_ready_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_ready && ecc_done) |=> ctrl_ready);
   assert_fail_nocount_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dec_fail |-> (dec_corr == 3'd0 && !dec_errs));
   assert_status_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({dec_fail, dec_errs, dec_corr}) |-> $past(ecc_done && !ctrl_ready));
   assert_sub_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sub_idx) |->
         sub_idx == (($past(sub_idx) == SUB_W'(SUBPAGES - 1)) ? '0 : $past(sub_idx) + 1'b1));
   assert_busy_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_ready && (host_wr || host_rd)) |=> seq_err);
   assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      seq_err |=> seq_err);
endmodule

bind subpage_ecc_seq sp_seq_checker #(.SUBPAGES(SUBPAGES), .SUB_W(SUB_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
   .ctrl_ready(ctrl_ready), .ecc_start(ecc_start), .ecc_done(ecc_done),
   .seq_err(seq_err), .sub_idx(sub_idx), .dec_fail(dec_fail),
   .dec_errs(dec_errs), .dec_corr(dec_corr)
);

// File: tb/test_subpage_ecc_seq.sv
module test_subpage_ecc_seq;
   localparam int NW = 132;
   localparam int NSUB = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_wr = 0, host_rd = 0, host_half = 0;
   logic [1:0] host_sel = 0;
   logic [31:0] host_wdata = 0;
   logic [31:0] host_rdata;
   logic ctrl_ready, seq_err, dec_fail, dec_errs, ecc_start, ecc_mode;
   logic [2:0] sub_idx;
   logic [2:0] dec_corr;
   logic ecc_done = 0, ecc_fail = 0, ecc_errs = 0;
   logic [1:0] ecc_cnt = 0;
   logic [7:0] eng_addr = 0;
   logic eng_we = 0;
   logic [31:0] eng_wdata = 0;
   logic [31:0] eng_rdata;

   int n_cmp = 0, n_bad = 0;
   int exp_sub = 0;
   logic [31:0] exp_buf [NW];

   always #10 clk = ~clk;

   subpage_ecc_seq #(.PAGE_BYTES(4096)) i_subpage_ecc_seq (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_sel(host_sel), .host_half(host_half), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .ctrl_ready(ctrl_ready), .seq_err(seq_err),
      .sub_idx(sub_idx), .dec_fail(dec_fail), .dec_errs(dec_errs),
      .dec_corr(dec_corr), .ecc_start(ecc_start), .ecc_mode(ecc_mode),
      .ecc_done(ecc_done), .ecc_fail(ecc_fail), .ecc_errs(ecc_errs),
      .ecc_cnt(ecc_cnt), .eng_addr(eng_addr), .eng_we(eng_we),
      .eng_wdata(eng_wdata), .eng_rdata(eng_rdata)
   );

   task automatic report;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] pat(input int seed, input int k);
      return {8'(seed), 8'(k), 16'h5A00 ^ 16'(k * 7)};
   endfunction

   task automatic host_op(input logic wr, input logic [1:0] sel, input logic half,
                          input logic [31:0] d);
      @(negedge clk);
      host_wr = wr; host_rd = !wr; host_sel = sel; host_half = half; host_wdata = d;
      @(posedge clk);
      #2;
      host_wr = 0; host_rd = 0; host_half = 0;
   endtask

   task automatic eng_write(input int a, input logic [31:0] d);
      @(negedge clk);
      eng_we = 1; eng_addr = 8'(a); eng_wdata = d;
      @(posedge clk);
      #2;
      eng_we = 0;
   endtask

   task automatic finish_engine(input logic f, input logic e, input logic [1:0] c);
      @(negedge clk);
      ecc_done = 1; ecc_fail = f; ecc_errs = e; ecc_cnt = c;
      chk("R2 ready low before done", 32'(ctrl_ready), 32'd0);
      @(posedge clk);
      #2;
      ecc_done = 0; ecc_fail = 0; ecc_errs = 0; ecc_cnt = 0;
      chk("R2 ready back after done", 32'(ctrl_ready), 32'd1);
   endtask

   task automatic do_decode(input logic f, input logic e, input logic [1:0] c,
                            input bit fill, input int seed);
      host_op(1, 2'd3, 0, 0);
      chk("R4 start pulse", 32'(ecc_start), 32'd1);
      chk("R4 mode decode", 32'(ecc_mode), 32'd1);
      chk("R4 ready low", 32'(ctrl_ready), 32'd0);
      if (fill) begin
         for (int k = 0; k < NW; k++) begin
            eng_write(k, pat(seed, k));
            exp_buf[k] = pat(seed, k);
         end
      end
      finish_engine(f, e, c);
      chk("R5 dec_fail", 32'(dec_fail), 32'(f));
      chk("R5 dec_errs", 32'(dec_errs), 32'(!f && e));
      chk("R5 dec_corr", 32'(dec_corr), (!f && e) ? 32'(c) + 1 : 32'd0);
      for (int k = 0; k < NW; k++) begin
         @(negedge clk);
         host_rd = 1; host_sel = 2'd0;
         #1;
         chk($sformatf("R4 drain word %0d", k), host_rdata, exp_buf[k]);
         @(posedge clk);
         #2;
         host_rd = 0;
      end
      exp_sub = (exp_sub + 1) % NSUB;
      chk("R6 sub_idx after decode", 32'(sub_idx), 32'(exp_sub));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      chk("R1 ready", 32'(ctrl_ready), 32'd1);
      chk("R1 seq_err", 32'(seq_err), 32'd0);
      chk("R1 sub_idx", 32'(sub_idx), 32'd0);
      chk("R1 ecc_start", 32'(ecc_start), 32'd0);
      chk("R1 status", {29'd0, dec_fail, dec_errs, 1'b0} | 32'(dec_corr), 32'd0);
      rst_n = 1;

      // first decode fills the buffer with a known pattern, no errors
      do_decode(0, 0, 2'd0, 1, 8'h11);
      chk("R7 no error yet", 32'(seq_err), 32'd0);

      // write frame with illegal accesses mixed in
      host_op(1, 2'd1, 0, 0);
      chk("R2 ready after open", 32'(ctrl_ready), 32'd1);
      chk("R2 no start on open", 32'(ecc_start), 32'd0);
      host_op(0, 2'd0, 0, 0);
      chk("R7 read during fill flags", 32'(seq_err), 32'd1);
      for (int k = 0; k < 128; k++) begin
         host_op(1, 2'd0, 0, pat(8'h22, k));
         exp_buf[k] = pat(8'h22, k);
      end
      host_op(1, 2'd0, 1, 32'h0000DEAD);
      host_op(1, 2'd0, 0, 32'hC0DE1234);
      exp_buf[128] = 32'hC0DE1234;
      host_op(1, 2'd2, 0, 0);
      chk("R7 early trigger no start", 32'(ecc_start), 32'd0);
      chk("R7 early trigger stays ready", 32'(ctrl_ready), 32'd1);
      host_op(1, 2'd0, 1, 32'h7777BEEF);
      exp_buf[129] = {exp_buf[129][31:16], 16'hBEEF};
      host_op(1, 2'd2, 0, 0);
      chk("R2 start pulse", 32'(ecc_start), 32'd1);
      chk("R2 mode encode", 32'(ecc_mode), 32'd0);
      chk("R2 ready low", 32'(ctrl_ready), 32'd0);
      for (int k = 0; k < 130; k++) begin
         @(negedge clk);
         eng_addr = 8'(k);
         #1;
         chk($sformatf("R3 engine view word %0d", k), eng_rdata, exp_buf[k]);
      end
      eng_write(130, 32'hA1A2A3A4);
      eng_write(131, 32'hB1B2B3B4);
      exp_buf[130] = 32'hA1A2A3A4;
      exp_buf[131] = 32'hB1B2B3B4;
      finish_engine(0, 1, 2'd2);
      exp_sub = (exp_sub + 1) % NSUB;
      chk("R6 sub_idx after encode", 32'(sub_idx), 32'(exp_sub));
      chk("R5 status kept over encode", {29'd0, dec_fail, dec_errs, 1'b0} | 32'(dec_corr), 32'd0);

      // engine write while idle must be ignored (R4)
      eng_write(0, 32'hFFFF0000);
      do_decode(1, 1, 2'd3, 0, 0);

      // sweep corrected counts, then a clean one, wrapping the page
      for (int c = 0; c < 4; c++) do_decode(0, 1, 2'(c), 1, 8'h30 + c);
      do_decode(0, 0, 2'd0, 1, 8'h40);
      chk("R6 wrap to zero", 32'(sub_idx), 32'd0);

      // access while busy
      host_op(1, 2'd3, 0, 0);
      host_op(0, 2'd0, 0, 0);
      finish_engine(0, 0, 2'd0);
      chk("R7 sticky", 32'(seq_err), 32'd1);
      report();
      $finish;
   end
endmodule